// File: doc/BRIEF.md
# Bus-Activity Quiet-Period Conversion Gate

This block sits between a successive-approximation conversion sequencer and the monitor of a serial bus. The sequencer issues a one-cycle request when it wants to take the sample and another each time it wants to decide a bit. When delaying is enabled, the gate holds a request for as long as the bus monitor reports activity. It releases the matching enable strobe in the first quiet cycle, so every analog decision is made while the bus is quiet. Postponing events this way can lengthen a conversion.

Each event type has its own control input, and both are active low. A 0 leaves delaying on; a 1 turns it off, and the request then goes straight to the strobe in the same cycle. The resting state of both inputs (0) therefore keeps both delay mechanisms on. A held bit trial may not wait longer than a set number of clock cycles, sized to about one microsecond. If it does, the gate raises a one-cycle abort pulse, drops every held request, and ignores bit-trial requests until the sequencer begins a new conversion with a sample request.

Top module: `busq_gate`

## Requirements
- R1: While reset is applied and after it is released, with no request present, samp_en, trial_en and conv_abort are all 0, and no request held before reset is granted afterwards.
- R2: With a control input at 1 (samp_nodly or trial_nodly), a request of that type drives its strobe high in the same cycle, whatever the state of bus_busy.
- R3: With a control input at 0 and bus_busy low, a request drives its strobe high in the same cycle.
- R4: With a control input at 0 and bus_busy high, a request is held and its strobe stays low; exactly one strobe follows, in the first cycle that bus_busy is low.
- R5: A held sample request has no time limit: it never causes conv_abort, however long bus_busy stays high.
- R6: A bit-trial request that meets bus_busy high in its request cycle and in each of the next STALL_MAX cycles produces conv_abort high for exactly one cycle, STALL_MAX cycles after the request, with no trial strobe.
- R7: If bus_busy falls STALL_MAX cycles after a held bit-trial request, trial_en goes high in that cycle and conv_abort stays low.
- R8: A new bit-trial request that arrives while an earlier one is held restarts the stall window from the new request.
- R9: After conv_abort, held sample and bit-trial requests are discarded. Bit-trial requests give no strobe, even with trial_nodly at 1, until a sample request arrives. The sample request itself is granted as usual, and bit trials are accepted again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_busy | input | 1 | High while the serial bus shows activity |
| samp_req | input | 1 | One-cycle request to take the sample |
| trial_req | input | 1 | One-cycle request to decide a bit |
| samp_nodly | input | 1 | 0 holds sample requests off during bus activity, 1 passes them through |
| trial_nodly | input | 1 | 0 holds bit-trial requests off during bus activity, 1 passes them through |
| samp_en | output | 1 | Sample-enable strobe |
| trial_en | output | 1 | Bit-trial-enable strobe |
| conv_abort | output | 1 | One-cycle pulse when a bit-trial stall exceeds its limit |

## Verification
The bench drives the stall window to both of its edges. A release in the last allowed cycle must give a strobe; one more busy cycle must give the abort. A design with an off-by-one window would abort early in the first case or grant late in the second. A repeated request inside the window must push the abort out. A design that does not restart the counter would abort three cycles early. After an abort, the bench releases the bus with a sample still held and sends trial requests in both delay modes. A design that keeps stale requests or forgets the blocked state would show a sample strobe or a trial strobe where none belongs. A sample held far past the limit checks that only bit trials are timed.

// File: rtl/busq_pkg.sv
package busq_pkg;
  typedef struct packed {
    logic grant;
    logic timeout;
  } busq_chan_out_t;

  function automatic int unsigned busq_cnt_width(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/busq_hold.sv
module busq_hold #(
  parameter int unsigned STALL_MAX = 125,
  parameter bit          TIMED     = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    bypass,
  input  logic                    busy,
  input  logic                    flush,
  output busq_pkg::busq_chan_out_t chan_o
);
  localparam int unsigned CW = busq_pkg::busq_cnt_width(STALL_MAX);
  localparam logic [CW-1:0] CNT_TOP = CW'(STALL_MAX);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          want, grant, timeout;

  assign want  = req | pend_q;
  assign grant = want & (bypass | ~busy);

  generate
    if (TIMED) begin : g_timed
      assign timeout = pend_q & ~req & ~bypass & busy & (cnt_q >= CNT_TOP);
    end else begin : g_untimed
      assign timeout = 1'b0;
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (grant) begin
      pend_d = 1'b0;
    end else if (req) begin
      pend_d = 1'b1;
      cnt_d  = CNT_ONE;
    end else if (flush | timeout) begin
      pend_d = 1'b0;
    end else if (pend_q & busy & (cnt_q != CNT_TOP)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign chan_o.grant   = grant;
  assign chan_o.timeout = timeout;
endmodule

// File: rtl/busq_block.sv
module busq_block (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic restart,
  output logic blocked
);
  logic blk_q, blk_d;

  always_comb begin
    blk_d = blk_q;
    if (restart)    blk_d = 1'b0;
    else if (abort) blk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= blk_d;
  end

  assign blocked = blk_q;
endmodule

// File: rtl/busq_gate.sv
module busq_gate #(
  parameter int unsigned STALL_MAX = 125,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_busy,
  input  logic samp_req,
  input  logic trial_req,
  input  logic samp_nodly,
  input  logic trial_nodly,
  output logic samp_en,
  output logic trial_en,
  output logic conv_abort
);
  localparam int unsigned SL = (SYNC_LEN < 1) ? 1 : SYNC_LEN;

  logic [SL-1:0] rst_pipe_q;
  logic          rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SL-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SL-1];

  busq_pkg::busq_chan_out_t samp_o, trial_o;
  logic blocked, trial_live, abort;

  assign trial_live = trial_req & ~blocked;
  assign abort      = trial_o.timeout;

  busq_hold #(.STALL_MAX(STALL_MAX), .TIMED(1'b0)) u_samp (
    .clk(clk), .rst_n(rst_int_n), .req(samp_req), .bypass(samp_nodly),
    .busy(bus_busy), .flush(abort), .chan_o(samp_o)
  );

  busq_hold #(.STALL_MAX(STALL_MAX), .TIMED(1'b1)) u_trial (
    .clk(clk), .rst_n(rst_int_n), .req(trial_live), .bypass(trial_nodly),
    .busy(bus_busy), .flush(abort), .chan_o(trial_o)
  );

  busq_block u_blk (
    .clk(clk), .rst_n(rst_int_n), .abort(abort), .restart(samp_req),
    .blocked(blocked)
  );

  assign samp_en    = samp_o.grant;
  assign trial_en   = trial_o.grant;
  assign conv_abort = abort;
endmodule

// File: rtl/busq_gate_chk.sv
module busq_gate_chk #(
  parameter int unsigned STALL_MAX = 125
) (
  input logic clk,
  input logic rst_n,
  input logic bus_busy,
  input logic samp_req,
  input logic samp_nodly,
  input logic trial_nodly,
  input logic samp_en,
  input logic trial_en,
  input logic conv_abort
);
  localparam int unsigned RW = busq_pkg::busq_cnt_width(STALL_MAX);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!bus_busy) run_q <= '0;
    else if (run_q != RW'(STALL_MAX)) run_q <= run_q + RW'(1);
  end

  AST_SAMP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_nodly && samp_req) |-> samp_en); // R2
  AST_SAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_nodly && samp_req && !bus_busy) |-> samp_en); // R3
  AST_SAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_nodly && bus_busy) |-> !samp_en); // R4
  AST_TRIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trial_nodly && bus_busy) |-> !trial_en); // R4
  AST_ABORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> (bus_busy && !trial_en)); // R6
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !conv_abort); // R6
  AST_ABORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> (run_q >= RW'(STALL_MAX))); // R6
  AST_ABORT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !trial_en); // R9
endmodule

bind busq_gate busq_gate_chk #(.STALL_MAX(STALL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .samp_req(samp_req),
  .samp_nodly(samp_nodly), .trial_nodly(trial_nodly), .samp_en(samp_en),
  .trial_en(trial_en), .conv_abort(conv_abort)
);

// File: tb/sim_busq_gate.sv
`timescale 1ns/1ps
module sim_busq_gate;
  localparam int unsigned LIM = 4;
  localparam int NV = 41;

  logic clk, rst_n, bus_busy, samp_req, trial_req, samp_nodly, trial_nodly;
  logic samp_en, trial_en, conv_abort;
  int total = 0, bad = 0;
  bit done = 0;

  busq_gate #(.STALL_MAX(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .samp_req(samp_req),
    .trial_req(trial_req), .samp_nodly(samp_nodly), .trial_nodly(trial_nodly),
    .samp_en(samp_en), .trial_en(trial_en), .conv_abort(conv_abort)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req_no[3:0], sr, tr, busy, sn, tn, exp_se, exp_te, exp_ab}
  localparam logic [11:0] VEC [NV] = '{
    {4'd3, 8'b10000100}, // 0  sample, quiet (R3)
    {4'd3, 8'b01000010}, // 1  trial, quiet (R3)
    {4'd4, 8'b01100000}, // 2  trial held (R4)
    {4'd4, 8'b00100000}, // 3
    {4'd4, 8'b00000010}, // 4  release (R4)
    {4'd4, 8'b00000000}, // 5  only one strobe (R4)
    {4'd5, 8'b10100000}, // 6  sample held (R5)
    {4'd5, 8'b00100000}, // 7
    {4'd5, 8'b00100000}, // 8
    {4'd5, 8'b00100000}, // 9
    {4'd5, 8'b00100000}, // 10
    {4'd5, 8'b00100000}, // 11
    {4'd5, 8'b00100000}, // 12
    {4'd5, 8'b00000100}, // 13 late sample grant (R5)
    {4'd2, 8'b01101010}, // 14 trial bypass busy (R2)
    {4'd2, 8'b10110100}, // 15 sample bypass busy (R2)
    {4'd7, 8'b01100000}, // 16 trial k0
    {4'd7, 8'b00100000}, // 17 k1
    {4'd7, 8'b00100000}, // 18 k2
    {4'd7, 8'b00100000}, // 19 k3
    {4'd7, 8'b00000010}, // 20 release at k=LIM (R7)
    {4'd8, 8'b01100000}, // 21 trial k0
    {4'd8, 8'b00100000}, // 22
    {4'd8, 8'b00100000}, // 23
    {4'd8, 8'b01100000}, // 24 re-request restarts (R8)
    {4'd8, 8'b00100000}, // 25 old window would abort here (R8)
    {4'd8, 8'b00100000}, // 26
    {4'd8, 8'b00100000}, // 27
    {4'd6, 8'b00100001}, // 28 abort (R6)
    {4'd6, 8'b00100000}, // 29 single pulse (R6)
    {4'd9, 8'b01000000}, // 30 trial blocked (R9)
    {4'd9, 8'b01001000}, // 31 blocked even in bypass (R9)
    {4'd9, 8'b10000100}, // 32 sample restarts (R9)
    {4'd9, 8'b01000010}, // 33 trials back (R9)
    {4'd9, 8'b11100000}, // 34 both held
    {4'd9, 8'b00100000}, // 35
    {4'd9, 8'b00100000}, // 36
    {4'd9, 8'b00100000}, // 37
    {4'd6, 8'b00100001}, // 38 abort (R6)
    {4'd9, 8'b00000000}, // 39 held sample dropped (R9)
    {4'd9, 8'b10000100}  // 40 new sample ok (R9)
  };

  task automatic check(input string rq, input string nm, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", rq, nm, act, exp);
    end
  endtask

  task automatic check3(input string rq, input logic se, input logic te, input logic ab);
    check(rq, "samp_en", samp_en, se);
    check(rq, "trial_en", trial_en, te);
    check(rq, "conv_abort", conv_abort, ab);
  endtask

  task automatic drive(input logic sr, input logic tr, input logic bz, input logic sn, input logic tn);
    samp_req = sr; trial_req = tr; bus_busy = bz; samp_nodly = sn; trial_nodly = tn;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    drive(0, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check3("R1", 1'b0, 1'b0, 1'b0);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check3("R1", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      @(negedge clk);
      check3($sformatf("R%0d row%0d", VEC[i][11:8], i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R1: a held trial is lost across reset
    @(posedge clk); #1 drive(0, 1, 1, 0, 0);
    @(posedge clk); #1 drive(0, 0, 1, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check3("R1", 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 drive(0, 0, 0, 0, 0);
    @(negedge clk);
    check3("R1", 1'b0, 1'b0, 1'b0);

    // R6 then R1: reset also lifts the trial block
    @(posedge clk); #1 drive(0, 1, 1, 0, 0);
    for (int k = 0; k < int'(LIM); k++) begin
      @(posedge clk); #1 drive(0, 0, 1, 0, 0);
    end
    @(negedge clk);
    check3("R6", 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1 drive(0, 0, 0, 0, 0);
    rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 drive(0, 1, 0, 0, 0);
    @(negedge clk);
    check3("R1", 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1 drive(0, 0, 0, 0, 0);
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule